// File: doc/BRIEF.md
# Per-Cell Exclusive Lock Table

This block sits on the request path in front of a memory slave. It decides, for each incoming request, whether that request may go on to the memory. A requester claims exclusive use of one memory cell by raising the lock flag on a request. From then on, the table remembers that cell's address together with the claimant's tag. A different tag that touches the same cell is held back until the owner lets go. Every other address, and every other requester working elsewhere, keeps getting grants in the same cycle.

A read-modify-write runs as a sequence of requests from one tag:

- a read to the cell with lock raised;
- a write to the cell with lock still raised, if wanted;
- a final access with lock lowered, which releases the cell.

The table has a fixed, small number of entries. A new claim that finds no free entry waits with stall raised, and a full flag is shown. All entries are compared against the request address in parallel, and grant or stall is decided combinationally in the cycle the request is presented. Table updates take effect at the next clock edge.

Top module: `lock_table`

## Requirements
- R1: After reset no cell is locked and `table_full_o` is 0. With `req_valid_i` low, `req_grant_o` and `req_stall_o` are both 0.
- R2: A valid request with lock low to an address that no entry holds is granted in the same cycle.
- R3: A valid request with lock high to an address that no entry holds is granted in the same cycle when an entry is free. From the next cycle on, that address is owned by the request's tag.
- R4: The owner's request with lock high to a cell it holds is granted, and the cell stays owned by it.
- R5: The owner's request with lock low to a cell it holds is granted, and the cell is free from the next cycle on.
- R6: A request from any tag other than the owner to a locked cell has stall high and grant low in every cycle it is presented. The same request is granted in the first cycle after the owner's release.
- R7: While a cell is locked, requests to other unlocked addresses from any tag are granted in the same cycle.
- R8: `table_full_o` is 1 exactly while every entry is in use. While it is 1, a lock-high request to an address no entry holds is stalled, and a lock-low request to such an address is still granted.
- R9: `req_grant_o` and `req_stall_o` are never 1 together, and when `req_valid_i` is 1 exactly one of them is 1.
- R10: While the table is full, an owner's lock-high request to a cell it already holds is granted, because it needs no new entry.
- R11: Different tags can each own different cells at the same time, and each is granted on its own cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | ADDR_W | Cell address of the request |
| req_tag_i | input | TAG_W | Requester identity |
| req_we_i | input | 1 | Write enable; carried with the request, no effect on locking |
| req_lock_i | input | 1 | 1 claims or keeps the cell, 0 on an owned cell releases it |
| req_grant_o | output | 1 | Request may proceed to memory this cycle |
| req_stall_o | output | 1 | Request is held; present it again |
| table_full_o | output | 1 | Every lock entry is in use |

## Verification
Two functions can meet in one cycle: the table being full, and a request that does not need a new entry. One case is an owner re-locking a cell it already holds. The other is a lock-low request to an unowned address. The bench fills every entry with distinct tags and then presents both kinds of request while the table is full. Both must be granted, while a fresh claim in the same state must stall. A second pair is a release followed by a waiting requester's retry. A non-owner is stalled over several cycles, the owner releases in one cycle, and the retry in the very next cycle must be granted.

// File: rtl/lock_table_pkg.sv
package lock_table_pkg;
  typedef enum logic [1:0] {
    DEC_PASS  = 2'd0,
    DEC_BLOCK = 2'd1,
    DEC_CLAIM = 2'd2,
    DEC_FREE  = 2'd3
  } lock_dec_e;
endpackage

// File: rtl/lock_entry.sv
module lock_entry #(
  parameter int ADDR_W = 16,
  parameter int TAG_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              used_o,
  output logic              hit_o,
  output logic [TAG_W-1:0]  owner_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [TAG_W-1:0]  tag_q;
  logic              used_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q <= 1'b0;
      addr_q <= '0;
      tag_q  <= '0;
    end else if (set_i) begin
      used_q <= 1'b1;
      addr_q <= addr_i;
      tag_q  <= tag_i;
    end else if (clr_i) begin
      used_q <= 1'b0;
    end
  end

  assign used_o  = used_q;
  assign hit_o   = used_q && (addr_q == addr_i);
  assign owner_o = tag_q;
endmodule

// File: rtl/lock_free_pick.sv
module lock_free_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] used_i,
  output logic         free_any_o,
  output logic [N-1:0] pick_o
);
  // lowest clear bit as a one-hot vector
  assign pick_o     = ~used_i & (used_i + N'(1));
  assign free_any_o = ~&used_i;
endmodule

// File: rtl/lock_decide.sv
module lock_decide
  import lock_table_pkg::*;
#(
  parameter int N     = 4,
  parameter int TAG_W = 4
) (
  input  logic                  valid_i,
  input  logic                  lock_i,
  input  logic [TAG_W-1:0]      tag_i,
  input  logic [N-1:0]          hit_i,
  input  logic [N-1:0][TAG_W-1:0] owner_i,
  input  logic                  free_any_i,
  output lock_dec_e             dec_o,
  output logic                  grant_o,
  output logic                  stall_o
);
  logic             hit_any;
  logic [TAG_W-1:0] hit_owner;
  logic             is_owner;

  always_comb begin
    hit_owner = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_i[i]) hit_owner = hit_owner | owner_i[i];
    end
  end

  assign hit_any  = |hit_i;
  assign is_owner = hit_any && (hit_owner == tag_i);

  always_comb begin
    if (!valid_i)                    dec_o = DEC_PASS;
    else if (hit_any && !is_owner)   dec_o = DEC_BLOCK;
    else if (hit_any)                dec_o = lock_i ? DEC_PASS : DEC_FREE;
    else if (lock_i && !free_any_i)  dec_o = DEC_BLOCK;
    else if (lock_i)                 dec_o = DEC_CLAIM;
    else                             dec_o = DEC_PASS;
  end

  assign stall_o = valid_i && (dec_o == DEC_BLOCK);
  assign grant_o = valid_i && (dec_o != DEC_BLOCK);
endmodule

// File: rtl/lock_table.sv
module lock_table
  import lock_table_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W      = 16,
  parameter int TAG_W       = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic              req_we_i,
  input  logic              req_lock_i,
  output logic              req_grant_o,
  output logic              req_stall_o,
  output logic              table_full_o
);
  localparam int N = NUM_ENTRIES;

  logic [N-1:0]            used_vec;
  logic [N-1:0]            hit_vec;
  logic [N-1:0][TAG_W-1:0] owner_vec;
  logic [N-1:0]            pick_vec;
  logic [N-1:0]            set_vec;
  logic [N-1:0]            clr_vec;
  logic                    free_any;
  lock_dec_e               dec;

  lock_free_pick #(.N(N)) u_pick (
    .used_i     (used_vec),
    .free_any_o (free_any),
    .pick_o     (pick_vec)
  );

  lock_decide #(.N(N), .TAG_W(TAG_W)) u_decide (
    .valid_i    (req_valid_i),
    .lock_i     (req_lock_i),
    .tag_i      (req_tag_i),
    .hit_i      (hit_vec),
    .owner_i    (owner_vec),
    .free_any_i (free_any),
    .dec_o      (dec),
    .grant_o    (req_grant_o),
    .stall_o    (req_stall_o)
  );

  assign set_vec = (dec == DEC_CLAIM) ? pick_vec : '0;
  assign clr_vec = (dec == DEC_FREE)  ? hit_vec  : '0;

  for (genvar g = 0; g < N; g++) begin : g_entry
    lock_entry #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_entry (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (set_vec[g]),
      .clr_i   (clr_vec[g]),
      .addr_i  (req_addr_i),
      .tag_i   (req_tag_i),
      .used_o  (used_vec[g]),
      .hit_o   (hit_vec[g]),
      .owner_o (owner_vec[g])
    );
  end

  assign table_full_o = &used_vec;
endmodule

// File: rtl/lock_table_chk.sv
module lock_table_chk #(
  parameter int N = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         req_valid_i,
  input logic         req_lock_i,
  input logic         req_we_i,
  input logic         req_grant_o,
  input logic         req_stall_o,
  input logic         table_full_o,
  input logic [N-1:0] used_vec,
  input logic [N-1:0] hit_vec
);
  logic hit_any;
  assign hit_any = |hit_vec;

  // R9
  grant_stall_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_grant_o && req_stall_o));

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!req_grant_o && !req_stall_o));

  // R3
  unique_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  // R3
  claim_adds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_grant_o && req_lock_i && !hit_any) |=>
      ($countones(used_vec) == $countones($past(used_vec)) + 1));

  // R5
  release_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_grant_o && !req_lock_i && hit_any) |=>
      ($countones(used_vec) + 1 == $countones($past(used_vec))));

  // R2
  open_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !hit_any && !req_lock_i) |-> req_grant_o);

  // R8
  miss_stall_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_stall_o && !hit_any) |-> (table_full_o && req_lock_i));

  // R4
  keep_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_grant_o && req_lock_i && hit_any) |=> $stable(used_vec));

  logic unused_we;
  assign unused_we = req_we_i;
endmodule

bind lock_table lock_table_chk #(.N(NUM_ENTRIES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_lock_i   (req_lock_i),
  .req_we_i     (req_we_i),
  .req_grant_o  (req_grant_o),
  .req_stall_o  (req_stall_o),
  .table_full_o (table_full_o),
  .used_vec     (used_vec),
  .hit_vec      (hit_vec)
);

// File: tb/lock_table_tb_top.sv
module lock_table_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [15:0] req_addr_i = '0;
  logic [3:0]  req_tag_i = '0;
  logic        req_we_i = 1'b0;
  logic        req_lock_i = 1'b0;
  logic        req_grant_o, req_stall_o, table_full_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  lock_table dut_i (.*);

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // present request between edges, sample 2 ns later
  task automatic put(input logic v, input logic [15:0] a, input logic [3:0] t,
                     input logic w, input logic l);
    @(negedge clk_i);
    req_valid_i = v; req_addr_i = a; req_tag_i = t; req_we_i = w; req_lock_i = l;
    #2;
  endtask

  task automatic expect_go(input string req, input logic go);
    check({req, " grant"}, req_grant_o, go);
    check({req, " stall"}, req_stall_o, !go);
  endtask

  task automatic t_reset();
    put(1'b0, 16'h0, 4'h0, 1'b0, 1'b0);
    check("R1 full", table_full_o, 1'b0);
    check("R1 grant idle", req_grant_o, 1'b0);
    check("R1 stall idle", req_stall_o, 1'b0);
    put(1'b1, 16'h0040, 4'h3, 1'b1, 1'b0);
    expect_go("R2 open write", 1'b1);
    put(1'b1, 16'h0041, 4'h5, 1'b0, 1'b0);
    expect_go("R2 open read", 1'b1);
  endtask

  task automatic t_rmw();
    put(1'b1, 16'h0010, 4'h1, 1'b0, 1'b1);
    expect_go("R3 claim", 1'b1);
    put(1'b1, 16'h0010, 4'h2, 1'b0, 1'b0);
    expect_go("R3 other blocked", 1'b0);
    put(1'b1, 16'h0020, 4'h2, 1'b1, 1'b0);
    expect_go("R7 other addr", 1'b1);
    put(1'b1, 16'h0010, 4'h1, 1'b1, 1'b1);
    expect_go("R4 owner write", 1'b1);
    put(1'b1, 16'h0010, 4'h2, 1'b1, 1'b1);
    expect_go("R4 still owned", 1'b0);
    put(1'b1, 16'h0010, 4'h1, 1'b0, 1'b0);
    expect_go("R5 release", 1'b1);
    put(1'b1, 16'h0010, 4'h2, 1'b0, 1'b0);
    expect_go("R5 freed", 1'b1);
  endtask

  task automatic t_hold();
    put(1'b1, 16'h0300, 4'h7, 1'b0, 1'b1);
    expect_go("R3 claim h", 1'b1);
    for (int i = 0; i < 3; i++) begin
      put(1'b1, 16'h0300, 4'h9, 1'b1, 1'b0);
      expect_go("R6 held", 1'b0);
    end
    put(1'b1, 16'h0300, 4'h7, 1'b1, 1'b0);
    expect_go("R5 owner frees", 1'b1);
    put(1'b1, 16'h0300, 4'h9, 1'b1, 1'b0);
    expect_go("R6 retry granted", 1'b1);
  endtask

  task automatic t_full();
    for (int i = 0; i < 4; i++) begin
      put(1'b1, 16'h0500 + 16'(i), 4'(i + 1), 1'b0, 1'b1);
      expect_go("R11 claim distinct", 1'b1);
    end
    put(1'b0, 16'h0, 4'h0, 1'b0, 1'b0);
    check("R8 full set", table_full_o, 1'b1);
    put(1'b1, 16'h0599, 4'h5, 1'b0, 1'b1);
    expect_go("R8 claim when full", 1'b0);
    put(1'b1, 16'h0599, 4'h5, 1'b1, 1'b0);
    expect_go("R8 open when full", 1'b1);
    put(1'b1, 16'h0500, 4'h1, 1'b0, 1'b1);
    expect_go("R10 relock full", 1'b1);
    put(1'b1, 16'h0502, 4'h3, 1'b0, 1'b1);
    expect_go("R11 own cell", 1'b1);
    put(1'b1, 16'h0502, 4'h1, 1'b0, 1'b0);
    expect_go("R11 foreign cell", 1'b0);
    put(1'b1, 16'h0501, 4'h2, 1'b1, 1'b0);
    expect_go("R5 free one", 1'b1);
    put(1'b0, 16'h0, 4'h0, 1'b0, 1'b0);
    check("R8 full clear", table_full_o, 1'b0);
    put(1'b1, 16'h0599, 4'h5, 1'b0, 1'b1);
    expect_go("R8 claim after free", 1'b1);
    put(1'b0, 16'h0, 4'h0, 1'b0, 1'b0);
    check("R8 full again", table_full_o, 1'b1);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    t_reset();
    t_rmw();
    t_hold();
    t_full();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule